// File: doc/BRIEF.md
# Floating-Point Compare into a Condition Field

The block compares two IEEE-754 operands and places a 4-bit verdict into one field of a 32-bit condition register. It has three formats: a scalar single-precision compare on the low word of each operand, a scalar double-precision compare on the full 64 bits, and a paired compare that treats each 64-bit operand as two single-precision lanes. A 2-bit predicate selects the test: equal, greater-than or less-than.

Each compare first resolves to one of four outcomes: less, equal, greater or unordered. The predicate holds only when the outcome is the matching ordered one. The caller supplies the current condition register. One cycle after a request, the block returns that register with only the addressed field rewritten, and raises an invalid-operation flag when a signalling NaN took part in the compare.

Top module: `fcmp_crfield`

## Requirements
- R1: While `rstN` is low, and in the cycle after it rises, `crOut` is 0, `outValid` is 0 and `invalidFlag` is 0.
- R2: A request sampled with `inValid` high at a clock edge produces its result at that edge. `outValid` is 1 for exactly the one following cycle, and `outValid` is never 1 without a request at the previous edge.
- R3: The outcome follows the values of the operands:
  - +0 and -0 are equal.
  - Subnormals are ordered by value.
  - Infinities are ordered beyond every finite value.
  - Any NaN (exponent all ones, mantissa nonzero) makes the outcome unordered.
- R4: Predicate codes are 2'b00 equal, 2'b01 greater-than (opA > opB), 2'b10 less-than (opA < opB) and 2'b11 reserved. The reserved code never holds, and an unordered outcome satisfies no predicate.
- R5: The format code selects the scalar compares:
  - 2'b00 compares `opA[31:0]` with `opB[31:0]` as single precision and ignores the upper words.
  - 2'b01 compares the full 64 bits as double precision.
  - 2'b11 behaves as 2'b00.
  - A scalar result field is 4'b0100 when the predicate holds and 4'b0000 otherwise.
- R6: Format 2'b10 is the paired compare. Let h be the predicate result for bits 63:32 and l the result for bits 31:0. The field is {h, l, h|l, h&l}, most significant bit first.
- R7: The field index `fieldIdx` places the 4-bit field at `crOut` bits [(7-fieldIdx)*4 +: 4], so index 0 is bits 31:28 and index 7 is bits 3:0.
- R8: Every bit of `crOut` outside the addressed field equals the corresponding bit of `crIn` sampled with the request.
- R9: `invalidFlag` is 1 alongside a result exactly when a compared operand word is a signalling NaN (exponent all ones, mantissa nonzero, top mantissa bit 0). Quiet NaNs do not raise it, and words that the format ignores do not count.
- R10: In a cycle with no result, `crOut` holds its last value and `invalidFlag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| fmt | input | 2 | Format: 00 single, 01 double, 10 paired, 11 as single |
| pred | input | 2 | Predicate: 00 equal, 01 greater, 10 less, 11 reserved |
| fieldIdx | input | 3 | Destination condition field |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| crIn | input | 32 | Current condition register |
| crOut | output | 32 | Updated condition register |
| outValid | output | 1 | Result strobe |
| invalidFlag | output | 1 | Signalling-NaN invalid-operation flag |

## Verification
The assertions check the cycle-level shape of the block on every cycle:
- the result strobe follows each request by one cycle and appears at no other time;
- the register holds between results;
- bits outside the addressed field match the captured input;
- a scalar field is 0000 or 0100, and a paired field carries consistent OR and AND bits;
- the flag appears only with a result.

Whether the verdict itself is correct can only be shown by the bench's scenarios, which compare the outputs against an independent reference:
- the ordering of signed zeros, subnormals and infinities;
- unordered NaN handling;
- predicate selection;
- lane placement in the paired format;
- field position and the signalling-NaN flag.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  localparam int SGL_EXP_W = 8;
  localparam int SGL_MAN_W = 23;
  localparam int DBL_EXP_W = 11;
  localparam int DBL_MAN_W = 52;
  localparam int SGL_W     = SGL_EXP_W + SGL_MAN_W + 1;
  localparam int DBL_W     = DBL_EXP_W + DBL_MAN_W + 1;
  localparam int FIELD_W   = 4;
  localparam int LANES     = DBL_W / SGL_W;

  typedef enum logic [1:0] {
    CMP_LT = 2'd0,
    CMP_EQ = 2'd1,
    CMP_GT = 2'd2,
    CMP_UN = 2'd3
  } cmpOutcome_t;

  typedef enum logic [1:0] {
    PRED_EQ  = 2'd0,
    PRED_GT  = 2'd1,
    PRED_LT  = 2'd2,
    PRED_RSV = 2'd3
  } cmpPred_t;

  localparam logic [1:0] FMT_SGL  = 2'd0;
  localparam logic [1:0] FMT_DBL  = 2'd1;
  localparam logic [1:0] FMT_PAIR = 2'd2;

  typedef struct packed {
    logic load;
    logic useDbl;
    logic usePair;
  } ctrlStrobe_t;

  function automatic logic predHit(input logic [1:0] p, input cmpOutcome_t o);
    case (p)
      PRED_EQ: predHit = (o == CMP_EQ);
      PRED_GT: predHit = (o == CMP_GT);
      PRED_LT: predHit = (o == CMP_LT);
      default: predHit = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/fcmp_lane.sv
module fcmp_lane
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] a,
  input  logic [EXP_W+MAN_W:0] b,
  output cmpOutcome_t          outcome,
  output logic                 sigNan
);

  localparam int W = EXP_W + MAN_W + 1;

  logic aNan, bNan, aSnan, bSnan, aZero, bZero, magGt;

  always_comb begin
    aNan  = (&a[W-2:MAN_W]) && (|a[MAN_W-1:0]);
    bNan  = (&b[W-2:MAN_W]) && (|b[MAN_W-1:0]);
    aSnan = aNan && !a[MAN_W-1];
    bSnan = bNan && !b[MAN_W-1];
    aZero = ~|a[W-2:0];
    bZero = ~|b[W-2:0];
    magGt = a[W-2:0] > b[W-2:0];

    if (aNan || bNan)                 outcome = CMP_UN;
    else if (aZero && bZero)          outcome = CMP_EQ;
    else if (a[W-1] != b[W-1])        outcome = a[W-1] ? CMP_LT : CMP_GT;
    else if (a[W-2:0] == b[W-2:0])    outcome = CMP_EQ;
    else                              outcome = (magGt ^ a[W-1]) ? CMP_GT : CMP_LT;

    sigNan = aSnan || bSnan;
  end

endmodule

// File: rtl/fcmp_ctrl.sv
module fcmp_ctrl
  import fcmp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [1:0]  fmt,
  output ctrlStrobe_t strobe,
  output logic        outValid
);

  always_comb begin
    strobe.load    = inValid;
    strobe.useDbl  = (fmt == FMT_DBL);
    strobe.usePair = (fmt == FMT_PAIR);
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/fcmp_datapath.sv
module fcmp_datapath
  import fcmp_pkg::*;
#(
  parameter int CR_FIELDS = 8,
  localparam int CR_W  = CR_FIELDS * FIELD_W,
  localparam int IDX_W = $clog2(CR_FIELDS),
  localparam int SH_W  = $clog2(CR_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [1:0]        pred,
  input  logic [IDX_W-1:0]  fieldIdx,
  input  logic [DBL_W-1:0]  opA,
  input  logic [DBL_W-1:0]  opB,
  input  logic [CR_W-1:0]   crIn,
  output logic [CR_W-1:0]   crOut,
  output logic              invalidFlag
);

  cmpOutcome_t laneOut [LANES];
  logic [LANES-1:0] laneSnan;
  logic [LANES-1:0] laneHit;
  cmpOutcome_t dblOut;
  logic dblSnan;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : gLane
      fcmp_lane #(.EXP_W(SGL_EXP_W), .MAN_W(SGL_MAN_W)) u_lane (
        .a      (opA[g*SGL_W +: SGL_W]),
        .b      (opB[g*SGL_W +: SGL_W]),
        .outcome(laneOut[g]),
        .sigNan (laneSnan[g])
      );
      assign laneHit[g] = predHit(pred, laneOut[g]);
    end
  endgenerate

  fcmp_lane #(.EXP_W(DBL_EXP_W), .MAN_W(DBL_MAN_W)) u_dbl (
    .a      (opA),
    .b      (opB),
    .outcome(dblOut),
    .sigNan (dblSnan)
  );

  logic [FIELD_W-1:0] fieldVal;
  logic               snanSel;
  logic               scalarHit;
  logic [SH_W-1:0]    pos;
  logic [CR_W-1:0]    mask;
  logic [CR_W-1:0]    newCr;

  always_comb begin
    scalarHit = strobe.useDbl ? predHit(pred, dblOut) : laneHit[0];
    if (strobe.usePair) begin
      fieldVal = {laneHit[1], laneHit[0], laneHit[1] | laneHit[0], laneHit[1] & laneHit[0]};
      snanSel  = |laneSnan;
    end else begin
      fieldVal = {1'b0, scalarHit, 2'b00};
      snanSel  = strobe.useDbl ? dblSnan : laneSnan[0];
    end
    pos   = SH_W'((CR_FIELDS - 1 - int'(fieldIdx)) * FIELD_W);
    mask  = {{(CR_W-FIELD_W){1'b0}}, {FIELD_W{1'b1}}} << pos;
    newCr = (crIn & ~mask) | ({{(CR_W-FIELD_W){1'b0}}, fieldVal} << pos);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crOut       <= '0;
      invalidFlag <= 1'b0;
    end else if (strobe.load) begin
      crOut       <= newCr;
      invalidFlag <= snanSel;
    end else begin
      invalidFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/fcmp_crfield.sv
module fcmp_crfield
  import fcmp_pkg::*;
#(
  parameter int CR_FIELDS = 8,
  localparam int CR_W  = CR_FIELDS * FIELD_W,
  localparam int IDX_W = $clog2(CR_FIELDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        fmt,
  input  logic [1:0]        pred,
  input  logic [IDX_W-1:0]  fieldIdx,
  input  logic [DBL_W-1:0]  opA,
  input  logic [DBL_W-1:0]  opB,
  input  logic [CR_W-1:0]   crIn,
  output logic [CR_W-1:0]   crOut,
  output logic              outValid,
  output logic              invalidFlag
);

  ctrlStrobe_t strobe;

  fcmp_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .fmt     (fmt),
    .strobe  (strobe),
    .outValid(outValid)
  );

  fcmp_datapath #(.CR_FIELDS(CR_FIELDS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .pred       (pred),
    .fieldIdx   (fieldIdx),
    .opA        (opA),
    .opB        (opB),
    .crIn       (crIn),
    .crOut      (crOut),
    .invalidFlag(invalidFlag)
  );

endmodule

// File: rtl/fcmp_crfield_chk.sv
module fcmp_crfield_chk
  import fcmp_pkg::*;
#(
  parameter int CR_FIELDS = 8,
  localparam int CR_W  = CR_FIELDS * FIELD_W,
  localparam int IDX_W = $clog2(CR_FIELDS),
  localparam int SH_W  = $clog2(CR_W)
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [1:0]        fmt,
  input logic [1:0]        pred,
  input logic [IDX_W-1:0]  fieldIdx,
  input logic [DBL_W-1:0]  opA,
  input logic [DBL_W-1:0]  opB,
  input logic [CR_W-1:0]   crIn,
  input logic [CR_W-1:0]   crOut,
  input logic              outValid,
  input logic              invalidFlag
);

  logic [SH_W-1:0]    curPos;
  logic [CR_W-1:0]    curMask;
  logic [SH_W-1:0]    prevPos;
  logic [CR_W-1:0]    prevMask;
  logic [CR_W-1:0]    prevCr;
  logic [1:0]         prevFmt;
  logic [FIELD_W-1:0] outField;

  always_comb begin
    curPos  = SH_W'((CR_FIELDS - 1 - int'(fieldIdx)) * FIELD_W);
    curMask = {{(CR_W-FIELD_W){1'b0}}, {FIELD_W{1'b1}}} << curPos;
  end

  always_ff @(posedge clk) begin
    prevPos  <= curPos;
    prevMask <= curMask;
    prevCr   <= crIn;
    prevFmt  <= fmt;
  end

  assign outField = FIELD_W'(crOut >> prevPos);

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R2
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(crOut) && !invalidFlag)); // R10
  AST_OTHER_FIELDS_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((crOut & ~prevMask) == (prevCr & ~prevMask))); // R8
  AST_SCALAR_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && prevFmt != FMT_PAIR) |-> (outField == 4'b0000 || outField == 4'b0100)); // R5
  AST_PAIR_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && prevFmt == FMT_PAIR) |->
      (outField[1] == (outField[3] | outField[2]) && outField[0] == (outField[3] & outField[2]))); // R6
  AST_FLAG_WITH_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    invalidFlag |-> outValid); // R9

endmodule

bind fcmp_crfield fcmp_crfield_chk #(.CR_FIELDS(CR_FIELDS)) u_chk (.*);

// File: tb/fcmp_crfield_bench.sv
module fcmp_crfield_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [1:0]  fmt;
  logic [1:0]  pred;
  logic [2:0]  fieldIdx;
  logic [63:0] opA, opB;
  logic [31:0] crIn;
  logic [31:0] crOut;
  logic        outValid;
  logic        invalidFlag;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fcmp_crfield u_fcmp_crfield (
    .clk(clk), .rstN(rstN), .inValid(inValid), .fmt(fmt), .pred(pred),
    .fieldIdx(fieldIdx), .opA(opA), .opB(opB), .crIn(crIn),
    .crOut(crOut), .outValid(outValid), .invalidFlag(invalidFlag)
  );

  // outcome codes used by the bench: 0 less, 1 equal, 2 greater, 3 unordered
  function automatic int refCmp32(input logic [31:0] a, input logic [31:0] b);
    longint ka, kb;
    if ((a[30:23] == 8'hff && a[22:0] != 0) || (b[30:23] == 8'hff && b[22:0] != 0)) return 3;
    ka = longint'(a[30:0]); if (a[31]) ka = -ka;
    kb = longint'(b[30:0]); if (b[31]) kb = -kb;
    return (ka < kb) ? 0 : (ka == kb) ? 1 : 2;
  endfunction

  function automatic int refCmp64(input logic [63:0] a, input logic [63:0] b);
    longint ka, kb;
    if ((a[62:52] == 11'h7ff && a[51:0] != 0) || (b[62:52] == 11'h7ff && b[51:0] != 0)) return 3;
    ka = longint'({1'b0, a[62:0]}); if (a[63]) ka = -ka;
    kb = longint'({1'b0, b[62:0]}); if (b[63]) kb = -kb;
    return (ka < kb) ? 0 : (ka == kb) ? 1 : 2;
  endfunction

  function automatic logic snan32(input logic [31:0] a);
    return a[30:23] == 8'hff && a[22:0] != 0 && !a[22];
  endfunction

  function automatic logic snan64(input logic [63:0] a);
    return a[62:52] == 11'h7ff && a[51:0] != 0 && !a[51];
  endfunction

  function automatic logic hit(input logic [1:0] p, input int o);
    return (p == 2'd0 && o == 1) || (p == 2'd1 && o == 2) || (p == 2'd2 && o == 0);
  endfunction

  function automatic logic [31:0] pickS(input logic [31:0] other);
    case ($urandom % 10)
      0: return other;
      1: return other ^ 32'h8000_0000;
      2: return 32'h0000_0000;
      3: return 32'h8000_0000;
      4: return {$urandom % 2 == 1, 8'hff, 23'h0};
      5: return 32'h7fc0_0000 | ($urandom & 32'h003f_ffff);
      6: return 32'h7f80_0001 | ($urandom & 32'h001f_ffff);
      7: return {$urandom % 2 == 1, 8'h00, 23'($urandom)};
      default: return $urandom;
    endcase
  endfunction

  function automatic logic [63:0] pickD(input logic [63:0] other);
    case ($urandom % 10)
      0: return other;
      1: return other ^ 64'h8000_0000_0000_0000;
      2: return 64'h0;
      3: return 64'h8000_0000_0000_0000;
      4: return {$urandom % 2 == 1, 11'h7ff, 52'h0};
      5: return 64'h7ff8_0000_0000_0000 | {32'h0, $urandom};
      6: return 64'h7ff0_0000_0000_0001 | {32'h0, $urandom};
      7: return {$urandom % 2 == 1, 11'h000, 20'($urandom), 32'($urandom)};
      default: return {$urandom, $urandom};
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic runOp(input logic [1:0] f, input logic [1:0] p, input logic [2:0] ix,
                       input logic [63:0] a, input logic [63:0] b, input logic [31:0] cr,
                       input string tag, input bit holdChk);
    logic [3:0]  fld;
    logic        ef, h, l;
    logic [31:0] ec, keep;
    int          sh;
    string       t;
    if (f == 2'd2) begin
      h   = hit(p, refCmp32(a[63:32], b[63:32]));
      l   = hit(p, refCmp32(a[31:0], b[31:0]));
      fld = {h, l, h | l, h & l};
      ef  = snan32(a[63:32]) | snan32(b[63:32]) | snan32(a[31:0]) | snan32(b[31:0]);
    end else if (f == 2'd1) begin
      fld = {1'b0, hit(p, refCmp64(a, b)), 2'b00};
      ef  = snan64(a) | snan64(b);
    end else begin
      fld = {1'b0, hit(p, refCmp32(a[31:0], b[31:0])), 2'b00};
      ef  = snan32(a[31:0]) | snan32(b[31:0]);
    end
    sh = (7 - int'(ix)) * 4;
    ec = (cr & ~(32'hf << sh)) | (32'(fld) << sh);
    t  = (tag != "") ? tag : ((f == 2'd2) ? "R6" : "R5");

    @(negedge clk);
    inValid = 1'b1; fmt = f; pred = p; fieldIdx = ix; opA = a; opB = b; crIn = cr;
    @(negedge clk);
    inValid = 1'b0; opA = {$urandom, $urandom}; opB = {$urandom, $urandom}; crIn = $urandom;
    check(outValid == 1'b1, "R2", "outValid after request", 64'(outValid), 64'd1);
    check(crOut == ec, t, "crOut", 64'(crOut), 64'(ec));
    check(invalidFlag == ef, "R9", "invalidFlag", 64'(invalidFlag), 64'(ef));
    if (holdChk) begin
      keep = crOut;
      @(negedge clk);
      check(outValid == 1'b0, "R2", "single-cycle outValid", 64'(outValid), 64'd0);
      check(crOut == keep, "R10", "crOut hold", 64'(crOut), 64'(keep));
      check(invalidFlag == 1'b0, "R10", "flag clear when idle", 64'(invalidFlag), 64'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] a, b;
    void'($urandom(32'd20240611));
    rstN = 1'b0; inValid = 1'b0; fmt = 2'd0; pred = 2'd0; fieldIdx = 3'd0;
    opA = '0; opB = '0; crIn = 32'hffff_ffff;
    repeat (3) @(negedge clk);
    check(crOut == 0 && outValid == 0 && invalidFlag == 0, "R1", "reset state",
          {crOut, 30'b0, outValid, invalidFlag}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 0 && crOut == 0, "R1", "first cycle after reset",
          {crOut, 31'b0, outValid}, 64'd0);

    // R3: signed zeros equal, subnormal above zero, infinity above max finite
    runOp(2'd0, 2'd0, 3'd2, 64'h0, 64'h8000_0000, 32'h0, "R3", 1'b1);
    runOp(2'd0, 2'd1, 3'd3, 64'h1, 64'h0, 32'h0, "R3", 1'b0);
    runOp(2'd0, 2'd1, 3'd4, 64'h7f80_0000, 64'h7f7f_ffff, 32'h0, "R3", 1'b0);
    runOp(2'd0, 2'd1, 3'd1, 64'hbf80_0000, 64'hc000_0000, 32'h0, "R3", 1'b0);
    // R4: less-than, reserved predicate, unordered never holds
    runOp(2'd0, 2'd2, 3'd5, 64'h3f80_0000, 64'h4000_0000, 32'h0, "R4", 1'b0);
    runOp(2'd0, 2'd3, 3'd5, 64'h3f80_0000, 64'h3f80_0000, 32'h0, "R4", 1'b0);
    runOp(2'd0, 2'd0, 3'd6, 64'h7fc0_0000, 64'h7fc0_0000, 32'h0, "R4", 1'b0);
    // R9: signalling NaN raises flag, quiet does not; ignored upper word does not
    runOp(2'd0, 2'd0, 3'd6, 64'h7f80_0001, 64'h3f80_0000, 32'h0, "R9", 1'b1);
    runOp(2'd0, 2'd0, 3'd6, 64'h7f80_0001_3f80_0000, 64'h3f80_0000, 32'h0, "R9", 1'b0);
    // R5: double and reserved format
    runOp(2'd1, 2'd2, 3'd0, 64'h3ff0_0000_0000_0000, 64'h4000_0000_0000_0000, 32'h0, "R5", 1'b0);
    runOp(2'd3, 2'd0, 3'd1, 64'h1234_5678_3f80_0000, 64'h3f80_0000, 32'h0, "R5", 1'b0);
    // R6: lane placement
    runOp(2'd2, 2'd0, 3'd2, 64'h3f80_0000_4000_0000, 64'h3f80_0000_3f80_0000, 32'h0, "R6", 1'b0);
    runOp(2'd2, 2'd1, 3'd2, 64'h3f80_0000_4000_0000, 64'h4000_0000_3f80_0000, 32'h0, "R6", 1'b0);
    // R7 / R8: field placement and preservation
    runOp(2'd0, 2'd0, 3'd0, 64'h0, 64'h0, 32'h0, "R7", 1'b0);
    runOp(2'd0, 2'd0, 3'd7, 64'h0, 64'h0, 32'h0, "R7", 1'b0);
    runOp(2'd0, 2'd1, 3'd4, 64'h0, 64'h0, 32'hffff_ffff, "R8", 1'b0);
    runOp(2'd2, 2'd0, 3'd3, 64'h0, 64'h0, 32'ha5a5_5a5a, "R8", 1'b1);

    for (int i = 0; i < 400; i++) begin
      logic [1:0] f;
      f = 2'($urandom);
      a = {$urandom, $urandom};
      if (f == 2'd1) b = pickD(a);
      else b = {pickS(a[63:32]), pickS(a[31:0])};
      if ($urandom % 4 == 0) a = (f == 2'd1) ? pickD(b) : {pickS(b[63:32]), pickS(b[31:0])};
      runOp(f, 2'($urandom), 3'($urandom), a, b, $urandom, "", (i % 7) == 0);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule